// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the device side of a legacy two-address configuration interface. A host reaches it through byte-wide I/O reads and writes. The lower address is an index port that selects a register. The upper address is a data port that reads or writes the selected register. The pair sits at one of two strap-selected base addresses.

The interface starts locked. To open it, the host writes a key byte to the index port twice in a row. The key is one of four values, chosen by a strap. The host locks it again by writing a fixed exit byte to the index port. While the interface is open, the host can reach:
- read-only vendor and chip identification registers;
- a logical-device selector;
- a per-channel bank for each of four serial channels, holding a 16-bit I/O base address and a transceiver control byte.

The channel base addresses and control bytes are also driven out as plain outputs, for use by the serial channels.

Host accesses are single-cycle strobes with no back-pressure. Any read that hits either port returns its data exactly one cycle later, with `rd_valid` set. The host must hold off nothing, and the block never stalls.

Top module: `cfgport_top`

## Requirements
- R1: Only `io_addr` equal to the base (index port) or base+1 (data port) has any effect. The base is 0x004E when `strap_base_sel`=0 and 0x002E when it is 1. Accesses to any other address change nothing and never raise `rd_valid`.
- R2: The interface opens (`cfg_active`=1 one cycle after the second write) only when the strap key is written to the index port in two consecutive index-port writes. The key is selected by `strap_key_sel`: 0 gives 0x77, 1 gives 0xA0, 2 gives 0x87 and 3 gives 0x67.
- R3: When the interface is not yet open, an index-port write that is not the key returns the unlock sequence to its start. Key, other byte, key therefore leaves it locked. A non-selected key written twice also leaves it locked.
- R4: Writing 0xAA to the index port while open locks the interface. That write does not change the index.
- R5: While locked, data-port writes change no register, and data-port and index-port reads return 0xFF.
- R6: A read that hits either port raises `rd_valid` for exactly the next cycle, with `rdata` holding the value. Otherwise `rd_valid` is 0 and `rdata` is 0x00. While open, an index-port read returns the current index.
- R7: Identification registers are read-only. Index 0x20 returns the chip ID low byte and 0x21 the high byte (parameter `CHIP_ID`, default 0x1602). Index 0x23 returns 0x19 and 0x24 returns 0x34. Unmapped indices read 0x00.
- R8: Index 0x07 holds a read/write logical-device number. Values 0 to 3 select the channel bank. Any larger value makes the bank indices read 0x00 and ignore writes.
- R9: In the selected bank, index 0x60 is the high byte and 0x61 the low byte of the channel base address. Reset values are 0x3F8, 0x2F8, 0x3E8 and 0x2E8 for channels 0 to 3, reflected on `ch_base`, with channel n at bits [16n+15:16n].
- R10: In the selected bank, index 0xF0 is the transceiver control byte. Bit 5 inverts RTS, bit 4 enables automatic direction control, bit 3 adds receive turnaround delay and bit 2 adds transmit pre-drive delay. Only bits 5:2 are stored; other bits read 0. It resets to 0 and appears on `ch_ctrl`, with channel n at bits [8n+7:8n].
- R11: After reset the interface is locked, the index and the logical-device number are 0, and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_base_sel | input | 1 | Base address select (0: 0x4E, 1: 0x2E) |
| strap_key_sel | input | 2 | Unlock key select |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| rd_valid | output | 1 | Read data valid, one cycle after a hit read |
| rdata | output | 8 | Read data |
| cfg_active | output | 1 | Configuration interface open |
| ch_base | output | 64 | Per-channel I/O base addresses |
| ch_ctrl | output | 32 | Per-channel transceiver control bytes |

## Verification
The hardest state to reach from the ports is a half-finished unlock sequence that gets interrupted. The block must forget the first key, yet still accept a fresh key pair right after. The stimulus builds this on purpose. It sends key, a foreign byte, then key, and checks that the port is still locked. It then sends a non-selected key pair, and only after that the correct pair. The out-of-range logical-device case is reached by writing selector values 4 and 5 during the seeded random phase. Bank writes that follow must leave every channel output unchanged.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] EXIT_CODE  = 8'hAA;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_CHIPLO = 8'h20;
  localparam logic [7:0] IDX_CHIPHI = 8'h21;
  localparam logic [7:0] IDX_VENA   = 8'h23;
  localparam logic [7:0] IDX_VENB   = 8'h24;
  localparam logic [7:0] IDX_BASEHI = 8'h60;
  localparam logic [7:0] IDX_BASELO = 8'h61;
  localparam logic [7:0] IDX_XCVR   = 8'hF0;
  localparam logic [7:0] VEN_A      = 8'h19;
  localparam logic [7:0] VEN_B      = 8'h34;
  localparam logic [7:0] XCVR_MASK  = 8'h3C;

  typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lock_state_e;

  function automatic logic [7:0] key_for(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h77;
      2'd1:    return 8'hA0;
      2'd2:    return 8'h87;
      default: return 8'h67;
    endcase
  endfunction

  function automatic logic [15:0] base_for(input int ch);
    case (ch)
      0:       return 16'h03F8;
      1:       return 16'h02F8;
      2:       return 16'h03E8;
      3:       return 16'h02E8;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic [7:0] key,
  output logic       open_o,
  output logic [7:0] idx_o
);
  lock_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= LK_IDLE;
      idx_o <= 8'h00;
    end else if (idx_wr) begin
      case (state)
        LK_IDLE: state <= (wdata == key) ? LK_HALF : LK_IDLE;
        LK_HALF: state <= (wdata == key) ? LK_OPEN : LK_IDLE;
        default: begin
          if (wdata == EXIT_CODE) state <= LK_IDLE;
          else                    idx_o <= wdata;
        end
      endcase
    end
  end

  assign open_o = (state == LK_OPEN);

  // R2: opening only follows a key write on the index port
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(idx_wr && (wdata == key)));

  // R4: exit byte closes the interface and leaves the index alone
  a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && idx_wr && (wdata == EXIT_CODE)) |=> (!open_o && $stable(idx_o)));
endmodule

// File: rtl/cfgport_chan.sv
module cfgport_chan
  import cfgport_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [15:0] base_o,
  output logic [7:0]  ctrl_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= base_for(CH);
      ctrl_o <= 8'h00;
    end else if (wr_en) begin
      case (idx)
        IDX_BASEHI: base_o[15:8] <= wdata;
        IDX_BASELO: base_o[7:0]  <= wdata;
        IDX_XCVR:   ctrl_o       <= wdata & XCVR_MASK;
        default: ;
      endcase
    end
  end

  // R10: unstored control bits never become set
  a_r10_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_o & ~XCVR_MASK) == 8'h00));
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int          NUM_CH   = 4,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CHIP_ID  = 16'h1602,
  parameter logic [15:0] PRI_BASE = 16'h004E,
  parameter logic [15:0] ALT_BASE = 16'h002E
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_base_sel,
  input  logic [1:0]            strap_key_sel,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic                  rd_valid,
  output logic [7:0]            rdata,
  output logic                  cfg_active,
  output logic [NUM_CH*16-1:0]  ch_base,
  output logic [NUM_CH*8-1:0]   ch_ctrl
);
  localparam int LDN_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [ADDR_W-1:0] base_addr;
  logic              hit_idx, hit_dat, idx_wr, dat_wr, ldn_ok;
  logic [7:0]        idx, ldn, rd_val, key;
  logic [15:0]       base_arr [NUM_CH];
  logic [7:0]        ctrl_arr [NUM_CH];
  logic [15:0]       sel_base;
  logic [7:0]        sel_ctrl;

  assign base_addr = strap_base_sel ? ADDR_W'(ALT_BASE) : ADDR_W'(PRI_BASE);
  assign hit_idx   = (io_addr == base_addr);
  assign hit_dat   = (io_addr == base_addr + ADDR_W'(1));
  assign idx_wr    = io_wr & hit_idx;
  assign dat_wr    = io_wr & hit_dat & cfg_active;
  assign ldn_ok    = (ldn < 8'(NUM_CH));
  assign key       = key_for(strap_key_sel);

  cfgport_unlock u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (io_wdata),
    .key    (key),
    .open_o (cfg_active),
    .idx_o  (idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          ldn <= 8'h00;
    else if (dat_wr && idx == IDX_LDN)   ldn <= io_wdata;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cfgport_chan #(.CH(g)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (dat_wr && ldn_ok && (ldn == 8'(g))),
      .idx    (idx),
      .wdata  (io_wdata),
      .base_o (base_arr[g]),
      .ctrl_o (ctrl_arr[g])
    );
    assign ch_base[g*16 +: 16] = base_arr[g];
    assign ch_ctrl[g*8 +: 8]   = ctrl_arr[g];
  end

  assign sel_base = ldn_ok ? base_arr[ldn[LDN_W-1:0]] : 16'h0000;
  assign sel_ctrl = ldn_ok ? ctrl_arr[ldn[LDN_W-1:0]] : 8'h00;

  always_comb begin
    rd_val = 8'h00;
    if (hit_idx) begin
      rd_val = cfg_active ? idx : 8'hFF;
    end else if (!cfg_active) begin
      rd_val = 8'hFF;
    end else begin
      case (idx)
        IDX_LDN:    rd_val = ldn;
        IDX_CHIPLO: rd_val = CHIP_ID[7:0];
        IDX_CHIPHI: rd_val = CHIP_ID[15:8];
        IDX_VENA:   rd_val = VEN_A;
        IDX_VENB:   rd_val = VEN_B;
        IDX_BASEHI: rd_val = sel_base[15:8];
        IDX_BASELO: rd_val = sel_base[7:0];
        IDX_XCVR:   rd_val = sel_ctrl;
        default:    rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= 8'h00;
    end else begin
      rd_valid <= io_rd & (hit_idx | hit_dat);
      rdata    <= (io_rd & (hit_idx | hit_dat)) ? rd_val : 8'h00;
    end
  end

  // R5: data writes while locked leave every channel register unchanged
  a_r5_locked_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_dat && !cfg_active) |=> ($stable(ch_base) && $stable(ch_ctrl)));

  // R6: valid read data only follows a read that hit a port
  a_r6_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(io_rd && (hit_idx || hit_dat)));

  // R8: an out-of-range device number blocks bank writes
  a_r8_ldn_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ldn_ok) |=> ($stable(ch_base) && $stable(ch_ctrl)));
endmodule

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_base_sel = 1'b0;
  logic [1:0]  strap_key_sel = 2'd1;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic        rd_valid, cfg_active;
  logic [7:0]  rdata;
  logic [63:0] ch_base;
  logic [31:0] ch_ctrl;

  localparam logic [15:0] CHIP = 16'h1602;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  m_ldn;
  logic [15:0] m_base [4];
  logic [7:0]  m_ctrl [4];

  always #2 clk = ~clk;

  cfgport_top dut (
    .clk(clk), .rst_n(rst_n), .strap_base_sel(strap_base_sel),
    .strap_key_sel(strap_key_sel), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .rd_valid(rd_valid), .rdata(rdata),
    .cfg_active(cfg_active), .ch_base(ch_base), .ch_ctrl(ch_ctrl)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic v, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); v = rd_valid; d = rdata; io_rd = 1'b0;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] idx);
    case (idx)
      8'h07: return m_ldn;
      8'h20: return CHIP[7:0];
      8'h21: return CHIP[15:8];
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      8'h60: return (m_ldn < 4) ? m_base[m_ldn[1:0]][15:8] : 8'h00;
      8'h61: return (m_ldn < 4) ? m_base[m_ldn[1:0]][7:0]  : 8'h00;
      8'hF0: return (m_ldn < 4) ? m_ctrl[m_ldn[1:0]] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] idx, input logic [7:0] d);
    if (idx == 8'h07) m_ldn = d;
    else if (m_ldn < 4) begin
      if (idx == 8'h60) m_base[m_ldn[1:0]][15:8] = d;
      if (idx == 8'h61) m_base[m_ldn[1:0]][7:0]  = d;
      if (idx == 8'hF0) m_ctrl[m_ldn[1:0]] = d & 8'h3C;
    end
  endfunction

  task automatic check_outputs(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, ch_base[c*16 +: 16], m_base[c]);
      chk(req, ch_ctrl[c*8 +: 8], m_ctrl[c]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [7:0] d;
    logic [7:0] idx;
    void'($urandom(32'd20240611));
    m_ldn = 0;
    m_base[0] = 16'h3F8; m_base[1] = 16'h2F8; m_base[2] = 16'h3E8; m_base[3] = 16'h2E8;
    for (int c = 0; c < 4; c++) m_ctrl[c] = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 locked", cfg_active, 0);
    chk("R11 rd_valid", rd_valid, 0);
    check_outputs("R9 R10 reset values");

    // R5: locked reads and writes
    rd(16'h004F, v, d);
    chk("R5 locked read valid", v, 1);
    chk("R5 locked data read", d, 8'hFF);
    rd(16'h004E, v, d);
    chk("R5 locked index read", d, 8'hFF);
    wr(16'h004F, 8'h55);
    check_outputs("R5 locked write ignored");

    // R1: off-address accesses
    wr(16'h0050, 8'hA0); wr(16'h0050, 8'hA0);
    chk("R1 foreign addr no unlock", cfg_active, 0);
    rd(16'h0050, v, d);
    chk("R1 foreign addr no valid", v, 0);
    chk("R6 rdata idle zero", d, 8'h00);

    // R3: broken sequences
    wr(16'h004E, 8'hA0); wr(16'h004E, 8'h11); wr(16'h004E, 8'hA0);
    chk("R3 broken sequence", cfg_active, 0);
    wr(16'h004E, 8'h00);
    wr(16'h004E, 8'h77); wr(16'h004E, 8'h77);
    chk("R3 wrong key", cfg_active, 0);

    // R2: unlock
    wr(16'h004E, 8'hA0);
    chk("R2 single key", cfg_active, 0);
    wr(16'h004E, 8'hA0);
    chk("R2 unlock", cfg_active, 1);

    // R7: identification
    wr(16'h004E, 8'h20); rd(16'h004F, v, d); chk("R7 chip lo", d, CHIP[7:0]);
    wr(16'h004F, 8'h00); rd(16'h004F, v, d); chk("R7 chip lo read-only", d, CHIP[7:0]);
    wr(16'h004E, 8'h21); rd(16'h004F, v, d); chk("R7 chip hi", d, CHIP[15:8]);
    wr(16'h004E, 8'h23); rd(16'h004F, v, d); chk("R7 vendor a", d, 8'h19);
    wr(16'h004E, 8'h24); rd(16'h004F, v, d); chk("R7 vendor b", d, 8'h34);
    rd(16'h004E, v, d); chk("R6 index readback", d, 8'h24);
    chk("R6 index read valid", v, 1);

    // R8 / R9 / R10 directed
    wr(16'h004E, 8'h07); wr(16'h004F, 8'h02); m_ldn = 2;
    rd(16'h004F, v, d); chk("R8 ldn readback", d, 8'h02);
    wr(16'h004E, 8'h60); rd(16'h004F, v, d); chk("R9 ch2 base hi", d, 8'h03);
    wr(16'h004E, 8'h61); wr(16'h004F, 8'h10); model_write(8'h61, 8'h10);
    rd(16'h004F, v, d); chk("R9 ch2 base lo write", d, 8'h10);
    wr(16'h004E, 8'hF0); wr(16'h004F, 8'hFF); model_write(8'hF0, 8'hFF);
    rd(16'h004F, v, d); chk("R10 ctrl mask", d, 8'h3C);
    check_outputs("R9 R10 outputs");
    wr(16'h004E, 8'h07); wr(16'h004F, 8'h05); m_ldn = 5;
    wr(16'h004E, 8'hF0); wr(16'h004F, 8'h24);
    rd(16'h004F, v, d); chk("R8 out of range read", d, 8'h00);
    check_outputs("R8 out of range write ignored");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: begin idx = 8'h07; d = 8'($urandom % 6); end
        1: begin
          case ($urandom % 3) 0: idx = 8'h60; 1: idx = 8'h61; default: idx = 8'hF0; endcase
          d = 8'($urandom);
        end
        2: begin idx = 8'($urandom); if (idx == 8'hAA) idx = 8'h20; d = 8'($urandom); end
        default: begin idx = 8'($urandom % 2 ? 8'hF0 : 8'h60); d = 8'h00; end
      endcase
      wr(16'h004E, idx);
      if (op != 3) begin wr(16'h004F, d); model_write(idx, d); end
      rd(16'h004F, v, d);
      chk("R8 R9 R10 random read", d, exp_read(idx));
      if (i % 16 == 0) check_outputs("R9 R10 random outputs");
    end

    // R4: exit
    wr(16'h004E, 8'h61);
    wr(16'h004E, 8'hAA);
    chk("R4 exit locks", cfg_active, 0);
    rd(16'h004F, v, d); chk("R4 locked after exit", d, 8'hFF);

    // R1 alternate base and R2 other key
    strap_base_sel = 1'b1; strap_key_sel = 2'd2;
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    chk("R1 old base inert", cfg_active, 0);
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    chk("R2 alt key unlock", cfg_active, 1);
    rd(16'h002E, v, d); chk("R4 index kept across exit", d, 8'h61);
    wr(16'h002E, 8'h23); rd(16'h002F, v, d); chk("R1 alt base vendor", d, 8'h19);
    check_outputs("R9 R10 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule